// File: doc/BRIEF.md
# Multichannel Audio Transmit FIFO

This block queues outgoing audio samples between a simple register bus and a serial audio transmitter. Software writes one sample per bus write to a data register, and the block keeps only the 24 sample bits. Each time the serializer asks for a sample, the block hands over the oldest queued entry. A 16-bit source sample is expected to arrive left-justified, so that its sign bit sits on bit 23.

The sample storage has a fixed size, but how many frames it may hold depends on the channel layout chosen in a format register. One channel allows 256 frames, two channels allow 128, three or four allow 64, and five to eight allow 32. A status register reports the queued occupancy in whole frames and two sticky error flags. A level interrupt asks software to refill once the queue has drained to half of its usable size. Software can empty the queue with a control bit, and any change of format also empties it.

Top module: `audio_tx_fifo`

## Requirements
- R1: The usable sample limit is the frame capacity times the channel count. The frame capacity is 256 for 1 channel, 128 for 2, 64 for 3 or 4, and 32 for 5 to 8. A full queue reports the frame capacity in the status frame field.
- R2: The format register (address 0) holds a mode in bits [6:4] and a channel field in bits [2:0], and it reads back both. Modes 0 and 1 give 1 channel, modes 2 and 3 give 2 channels, and modes 4 and 5 give the channel field plus 1. Mode codes 6 and 7 count as 1 channel.
- R3: A write to the data register (address 3) queues bits [23:0] of the write data and discards bits [31:24]. Samples leave on pop_data in the order they were written. pop_data shows the oldest entry while the queue is not empty, and each cycle with pop_req high removes one entry.
- R4: The status register (address 2) reports in bits [16:8] the number of complete frames queued, which is the queued sample count divided by the channel count, rounded down.
- R5: A data write while the queue is at its limit is dropped and sets the sticky overrun flag in status bit 4. The frame count does not change.
- R6: A pop while the queue is empty returns zero on pop_data and sets the sticky underrun flag in status bit 0.
- R7: Writing 1 to status bit 4 or status bit 0 clears only that flag. Writing 0 to a flag bit leaves it unchanged.
- R8: Control bit 20 (address 1) enables the interrupt. irq is high when that bit is set and the queued sample count is at or below half the usable limit. irq is low otherwise.
- R9: Writing 1 to control bit 0 empties the queue in one cycle and leaves the error flags unchanged. The flush bit always reads back as 0, while bit 20 keeps the value from the same write.
- R10: Every write to the format register empties the queue.
- R11: After reset the queue is empty, both flags are clear, the interrupt is disabled, the format register is zero (mono) and pop_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address: 0 format, 1 control, 2 status, 3 data |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pop_req | input | 1 | Serializer takes the current pop_data this cycle |
| pop_data | output | 24 | Oldest queued sample, or zero when empty |
| irq | output | 1 | Refill request, a level |

## Verification
Every register write takes effect on the clock edge that ends its bus cycle. The status read data and irq are combinational from that state, so they are correct in the cycle right after the write. The checks sample them at the next falling edge. pop_data is combinational from the head of the queue, so each pop is checked during its own cycle, just after pop_req rises, and the removal is then visible from the following cycle. The sweep covers every mode and every TDM channel count. For each one it fills the queue to the computed limit and checks irq on both sides of the half mark. It then forces one overflow, drains every sample in order and forces one underrun.

// File: rtl/atf_pkg.sv
package atf_pkg;

  typedef enum logic [1:0] {
    ADR_FMT  = 2'd0,
    ADR_CTRL = 2'd1,
    ADR_STAT = 2'd2,
    ADR_DATA = 2'd3
  } atf_addr_e;

  localparam int FMT_MODE_LSB  = 4;
  localparam int CTL_IRQ_BIT   = 20;
  localparam int CTL_FLUSH_BIT = 0;
  localparam int ST_FRM_LSB    = 8;
  localparam int ST_FRM_W      = 9;
  localparam int ST_OVR_BIT    = 4;
  localparam int ST_UND_BIT    = 0;

  localparam logic [2:0] MODE_MONO     = 3'd0;
  localparam logic [2:0] MODE_MONO_DLY = 3'd1;
  localparam logic [2:0] MODE_PCM      = 3'd2;
  localparam logic [2:0] MODE_I2S      = 3'd3;
  localparam logic [2:0] MODE_TDM      = 3'd4;
  localparam logic [2:0] MODE_TDM_DLY  = 3'd5;

  // channel count from the format fields (1..8)
  function automatic logic [3:0] chan_of(logic [2:0] mode, logic [2:0] low);
    logic [3:0] c;
    case (mode)
      MODE_PCM, MODE_I2S:     c = 4'd2;
      MODE_TDM, MODE_TDM_DLY: c = {1'b0, low} + 4'd1;
      default:                c = 4'd1;
    endcase
    return c;
  endfunction

  // frame capacity = sample capacity >> shift
  function automatic logic [1:0] cap_shift(logic [3:0] ch);
    logic [1:0] s;
    if (ch <= 4'd1)      s = 2'd0;
    else if (ch == 4'd2) s = 2'd1;
    else if (ch <= 4'd4) s = 2'd2;
    else                 s = 2'd3;
    return s;
  endfunction

  function automatic logic [15:0] sample_limit(logic [15:0] cap, logic [3:0] ch);
    logic [15:0] frames;
    frames = cap >> cap_shift(ch);
    return frames * {12'd0, ch};
  endfunction

  function automatic logic [15:0] frames_of(logic [15:0] cnt, logic [3:0] ch);
    return cnt / {12'd0, ch};
  endfunction

endpackage

// File: rtl/atf_cfg.sv
module atf_cfg #(
  parameter int SAMPLE_CAP = 256,
  parameter int CNT_W      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fmt_we,
  input  logic [2:0]       mode_in,
  input  logic [2:0]       low_in,
  output logic [2:0]       mode_q,
  output logic [2:0]       low_q,
  output logic [3:0]       chan,
  output logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] half
);
  import atf_pkg::*;

  localparam logic [15:0] CAP16 = 16'(SAMPLE_CAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      low_q  <= '0;
    end else if (fmt_we) begin
      mode_q <= mode_in;
      low_q  <= low_in;
    end
  end

  always_comb begin
    chan  = chan_of(mode_q, low_q);
    limit = CNT_W'(sample_limit(CAP16, chan));
    half  = limit >> 1;
  end

endmodule

// File: rtl/atf_store.sv
module atf_store #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 24,
  parameter int CNT_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head = mem[rd_ptr];

endmodule

// File: rtl/atf_flags.sv
module atf_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic r;
    always_ff @(posedge clk) begin
      if (!rst_n)      r <= 1'b0;
      else if (set[i]) r <= 1'b1;
      else if (clr[i]) r <= 1'b0;
    end
    assign q[i] = r;
  end

endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo #(
  parameter int SAMPLE_CAP = 256,
  parameter int DATA_W     = 24,
  parameter int BUS_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              pop_req,
  output logic [DATA_W-1:0] pop_data,
  output logic              irq
);
  import atf_pkg::*;

  localparam int CNT_W = $clog2(SAMPLE_CAP) + 1;

  logic wr_fmt, wr_ctrl, wr_stat, wr_data;
  logic [2:0] mode_q, low_q;
  logic [3:0] chan;
  logic [CNT_W-1:0] limit, half, count, frames;
  logic [DATA_W-1:0] head;
  logic irq_en, full, empty;
  logic ev_push, ev_drop, ev_pop, ev_starve, ev_flush;
  logic clr_ovr, clr_und;
  logic [1:0] flag_q;
  logic ovr, und;

  assign wr_fmt  = bus_wr && (bus_addr == ADR_FMT);
  assign wr_ctrl = bus_wr && (bus_addr == ADR_CTRL);
  assign wr_stat = bus_wr && (bus_addr == ADR_STAT);
  assign wr_data = bus_wr && (bus_addr == ADR_DATA);

  atf_cfg #(.SAMPLE_CAP(SAMPLE_CAP), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .fmt_we(wr_fmt),
    .mode_in(bus_wdata[FMT_MODE_LSB +: 3]), .low_in(bus_wdata[2:0]),
    .mode_q(mode_q), .low_q(low_q), .chan(chan), .limit(limit), .half(half)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       irq_en <= 1'b0;
    else if (wr_ctrl) irq_en <= bus_wdata[CTL_IRQ_BIT];
  end

  // queue events
  assign full      = (count >= limit);
  assign empty     = (count == '0);
  assign ev_flush  = wr_fmt || (wr_ctrl && bus_wdata[CTL_FLUSH_BIT]);
  assign ev_push   = wr_data && !full;
  assign ev_drop   = wr_data && full;
  assign ev_pop    = pop_req && !empty && !ev_flush;
  assign ev_starve = pop_req && empty;

  atf_store #(.DEPTH(SAMPLE_CAP), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(ev_flush),
    .push(ev_push), .wdata(bus_wdata[DATA_W-1:0]),
    .pop(ev_pop), .head(head), .count(count)
  );

  assign clr_ovr = wr_stat && bus_wdata[ST_OVR_BIT];
  assign clr_und = wr_stat && bus_wdata[ST_UND_BIT];

  atf_flags #(.N(2)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set({ev_drop, ev_starve}), .clr({clr_ovr, clr_und}), .q(flag_q)
  );
  assign ovr = flag_q[1];
  assign und = flag_q[0];

  assign frames   = CNT_W'(frames_of(16'(count), chan));
  assign pop_data = empty ? '0 : head;
  assign irq      = irq_en && (count <= half);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_FMT: begin
        bus_rdata[FMT_MODE_LSB +: 3] = mode_q;
        bus_rdata[2:0]               = low_q;
      end
      ADR_CTRL: bus_rdata[CTL_IRQ_BIT] = irq_en;
      ADR_STAT: begin
        bus_rdata[ST_FRM_LSB +: ST_FRM_W] = ST_FRM_W'(frames);
        bus_rdata[ST_OVR_BIT]             = ovr;
        bus_rdata[ST_UND_BIT]             = und;
      end
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/atf_checks.sv
module atf_checks #(
  parameter int CNT_W  = 9,
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  limit,
  input logic              pop_req,
  input logic [DATA_W-1:0] pop_data,
  input logic              ev_push,
  input logic              ev_drop,
  input logic              ev_pop,
  input logic              ev_starve,
  input logic              ev_flush,
  input logic              clr_ovr,
  input logic              ovr,
  input logic              und,
  input logic              irq,
  input logic              irq_en
);

  assert_within_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= limit);

  assert_push_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_push && !ev_pop && !ev_flush) |=> count == $past(count) + CNT_W'(1));

  assert_drop_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_drop && !ev_pop && !pop_req) |=> $stable(count));

  assert_drop_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> ovr);

  assert_ovr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr_ovr) |=> ovr);

  assert_starve_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && count == '0) |-> pop_data == '0);

  assert_starve_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_starve |=> und);

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flush |=> count == '0);

endmodule

bind audio_tx_fifo atf_checks #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .count(count), .limit(limit),
  .pop_req(pop_req), .pop_data(pop_data),
  .ev_push(ev_push), .ev_drop(ev_drop), .ev_pop(ev_pop),
  .ev_starve(ev_starve), .ev_flush(ev_flush), .clr_ovr(clr_ovr),
  .ovr(ovr), .und(und), .irq(irq), .irq_en(irq_en)
);

// File: tb/sim_audio_tx_fifo.sv
`timescale 1ns/1ps
module sim_audio_tx_fifo;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pop_req = 1'b0;
  logic [23:0] pop_data;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  audio_tx_fifo u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pop_req(pop_req),
    .pop_data(pop_data), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic do_pop(output logic [23:0] d);
    @(negedge clk);
    pop_req = 1'b1;
    #1;
    d = pop_data;
    @(negedge clk);
    pop_req = 1'b0;
  endtask

  function automatic int exp_chan(int mode, int low);
    if (mode == 2 || mode == 3) return 2;
    if (mode == 4 || mode == 5) return low + 1;
    return 1;
  endfunction

  function automatic int exp_fcap(int ch);
    if (ch == 1) return 256;
    if (ch == 2) return 128;
    if (ch <= 4) return 64;
    return 32;
  endfunction

  task automatic run_cfg(int idx, int mode, int low);
    int ch, fc, lim, hf;
    logic [31:0] r;
    logic [23:0] d;
    ch = exp_chan(mode, low);
    fc = exp_fcap(ch);
    lim = fc * ch;
    hf = lim / 2;
    bus_write(2'd0, 32'((mode << 4) | low));
    bus_read(2'd0, r);
    chk("R2 format readback", r, 32'((mode << 4) | low));
    bus_read(2'd2, r);
    chk("R10 empty after format", r, 32'h0);
    chk("R8 irq when empty", 32'(irq), 32'd1);
    for (int i = 0; i < lim; i++) begin
      bus_write(2'd3, {8'hA5, 8'(idx), 16'(i)});
      if (i + 1 == hf) chk("R8 irq at half", 32'(irq), 32'd1);
      if (i + 1 == hf + 1) chk("R8 irq above half", 32'(irq), 32'd0);
      if (i + 1 == lim - 1) begin
        bus_read(2'd2, r);
        chk("R4 partial frames", r, 32'(((lim - 1) / ch) << 8));
      end
    end
    bus_read(2'd2, r);
    chk("R1 full frame count", r, 32'(fc << 8));
    bus_write(2'd3, 32'h00FFFFFF);
    bus_read(2'd2, r);
    chk("R5 overrun dropped", r, 32'((fc << 8) | 32'h10));
    for (int i = 0; i < lim; i++) begin
      do_pop(d);
      chk("R3 order and width", 32'(d), {8'h00, 8'(idx), 16'(i)});
    end
    do_pop(d);
    chk("R6 empty pop zero", 32'(d), 32'h0);
    bus_read(2'd2, r);
    chk("R6 underrun flag", r, 32'h11);
    bus_write(2'd2, 32'h11);
    bus_read(2'd2, r);
    chk("R7 flags cleared", r, 32'h0);
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog all-reqs got=hang exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [23:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(2'd2, r); chk("R11 status reset", r, 32'h0);
    bus_read(2'd1, r); chk("R11 control reset", r, 32'h0);
    bus_read(2'd0, r); chk("R11 format reset", r, 32'h0);
    chk("R11 irq reset", 32'(irq), 32'd0);
    chk("R11 pop_data reset", 32'(pop_data), 32'h0);

    bus_write(2'd1, 32'h0010_0000);
    bus_read(2'd1, r); chk("R8 enable readback", r, 32'h0010_0000);
    chk("R8 irq enabled empty", 32'(irq), 32'd1);

    run_cfg(0, 0, 0);
    run_cfg(1, 1, 5);
    run_cfg(2, 2, 0);
    run_cfg(3, 3, 7);
    for (int low = 0; low < 8; low++) run_cfg(4 + low, 4, low);
    run_cfg(12, 5, 3);
    run_cfg(13, 6, 0);
    run_cfg(14, 7, 2);

    // flush keeps flags, self-clears
    bus_write(2'd0, 32'h0);
    do_pop(d);
    for (int i = 0; i < 10; i++) bus_write(2'd3, 32'(i + 1));
    bus_read(2'd2, r); chk("R4 ten mono frames", r, 32'h0A01);
    bus_write(2'd2, 32'h10);
    bus_read(2'd2, r); chk("R7 other flag kept", r, 32'h0A01);
    bus_write(2'd1, 32'h0010_0001);
    bus_read(2'd2, r); chk("R9 flush empties keeps flag", r, 32'h01);
    bus_read(2'd1, r); chk("R9 flush bit reads zero", r, 32'h0010_0000);
    do_pop(d); chk("R9 nothing left after flush", 32'(d), 32'h0);
    bus_write(2'd2, 32'h01);
    bus_read(2'd2, r); chk("R7 underrun cleared", r, 32'h0);

    // format rewrite flushes
    bus_write(2'd0, 32'h20);
    for (int i = 0; i < 5; i++) bus_write(2'd3, 32'(i));
    bus_read(2'd2, r); chk("R4 two pcm frames", r, 32'h0200);
    bus_write(2'd0, 32'h20);
    bus_read(2'd2, r); chk("R10 rewrite flushes", r, 32'h0);

    // interrupt disable
    bus_write(2'd1, 32'h0);
    chk("R8 irq disabled", 32'(irq), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule